// File: doc/BRIEF.md
# Serial SAR Converter Host Controller

This block runs one conversion at a time on an external 12-bit successive-approximation converter that talks over three wires: an active-low select, a serial clock driven by the host, and a serial data line driven by the converter. A start request in the idle state pulls select low. This wakes the converter and lets it track the input. Select stays low for a programmable number of system clock cycles and is then raised. That rising edge fixes the sampling instant and starts the conversion.

After select rises, the controller produces 16 serial clock pulses. The serial clock rests high. The converter changes its data line on each falling edge, and the controller captures on each rising edge. The first four bits of the frame must be zero, and the last twelve are the result, most significant bit first, in plain unsigned binary. The result appears on a 12-bit output with a one-cycle valid strobe. An error flag goes with the strobe when a leading bit was one.

The controller enforces a minimum start-to-start period so that the converter's throughput limit is never exceeded. Every conversion needs a fresh low phase on select, because the converter powers down after each one. Requests that arrive while a frame is running are dropped.

Top module: `sadc_host_ctrl`

## Requirements
- R1: During reset and right after it, select is high, the serial clock is high, busy is low, and the valid strobe and error flag are low.
- R2: When start_i is high in the idle state, select goes low and busy goes high on the next cycle.
- R3: Select stays low for exactly LOW_CYC system cycles per frame and then rises.
- R4: The serial clock never goes low while select is low. After select rises, exactly 16 low pulses are produced, each low for HALF_DIV system cycles, and the clock then rests high.
- R5: The data line is captured at each rising serial clock edge, the first captured bit being frame bit 15. Frame bits 11..0 appear on sample_o as an unsigned value, with sample_valid_o high for one cycle, in the cycle the 16th rising edge is driven.
- R6: frame_err_o is high together with sample_valid_o exactly when any of frame bits 15..12 was one, and it is low in all other cycles.
- R7: Two consecutive falling edges of select are at least PERIOD_CYC cycles apart. When start_i is held high, they are exactly PERIOD_CYC cycles apart.
- R8: start_i has no effect while busy is high: no extra select low phase and no extra sample.
- R9: busy stays high from the cycle after a start is accepted until the minimum period has elapsed, and it covers the valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request one conversion |
| busy_o | output | 1 | Frame in progress or period not yet elapsed |
| adc_cs_n_o | output | 1 | Converter select, active low |
| adc_sclk_o | output | 1 | Serial clock to the converter, rests high |
| adc_sdata_i | input | 1 | Serial data from the converter |
| sample_o | output | RES_W | Last conversion result, unsigned |
| sample_valid_o | output | 1 | One-cycle strobe for a new sample_o |
| frame_err_o | output | 1 | Leading bit was nonzero, valid with the strobe |

## Verification
Select falls one cycle after start_i is seen high and rises LOW_CYC cycles later. The first serial clock fall comes HALF_DIV cycles after that. Each clock phase lasts HALF_DIV cycles, and the valid strobe shares its cycle with the 16th rising edge. The bench samples every output on the falling system clock edge and measures the lengths of the select low phase and of each serial clock low phase by counting those samples. The start-to-start distance is taken from a cycle counter at each select fall. A scoreboard queue holds the expected sample and error flag for each frame and compares them in the cycle the strobe appears, so a missing, extra or early sample shows up as a queue mismatch.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAKE = 2'd1,
    ST_XFER = 2'd2,
    ST_REST = 2'd3
  } sadc_state_e;

endpackage

// File: rtl/sadc_frame_timer.sv
module sadc_frame_timer #(
  parameter int LOW_CYC    = 200,
  parameter int PERIOD_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic wake_i,
  output logic low_done_o,
  output logic period_done_o
);

  localparam int LW = $clog2(LOW_CYC + 1);
  localparam int PW = $clog2(PERIOD_CYC + 1);
  localparam logic [LW-1:0] LOW_LAST = LW'(LOW_CYC - 1);
  localparam logic [PW-1:0] PER_LAST = PW'(PERIOD_CYC - 2);
  localparam logic [PW-1:0] PER_SAT  = PW'(PERIOD_CYC);

  logic [LW-1:0] low_cnt_q, low_cnt_d;
  logic [PW-1:0] per_cnt_q, per_cnt_d;
  logic          per_en;

  // low-phase counter runs only while select is held low
  always_comb begin
    low_cnt_d = low_cnt_q;
    if (!wake_i) low_cnt_d = '0;
    else         low_cnt_d = low_cnt_q + 1'b1;
  end

  // period counter restarts on accept and saturates
  assign per_en = accept_i || (per_cnt_q != PER_SAT);

  always_comb begin
    per_cnt_d = per_cnt_q;
    if (accept_i)    per_cnt_d = '0;
    else if (per_en) per_cnt_d = per_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      per_cnt_q <= PER_SAT;
    end else begin
      low_cnt_q <= low_cnt_d;
      if (per_en) per_cnt_q <= per_cnt_d;
    end
  end

  assign low_done_o    = wake_i && (low_cnt_q == LOW_LAST);
  assign period_done_o = (per_cnt_q >= PER_LAST);

endmodule

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen #(
  parameter int HALF_DIV   = 4,
  parameter int FRAME_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic cap_o,
  output logic last_o
);

  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BW = $clog2(FRAME_BITS + 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_DIV - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_BITS - 1);

  logic [HW-1:0] hc_q, hc_d;
  logic [BW-1:0] bc_q, bc_d;
  logic          sclk_q, sclk_d;
  logic          toggle_w;

  assign toggle_w = run_i && (hc_q == HALF_LAST);
  // capture strobe coincides with the edge that drives the clock high
  assign cap_o    = toggle_w && !sclk_q;
  assign last_o   = cap_o && (bc_q == BIT_LAST);

  always_comb begin
    hc_d   = hc_q;
    bc_d   = bc_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      hc_d   = '0;
      bc_d   = '0;
      sclk_d = 1'b1;
    end else if (toggle_w) begin
      hc_d   = '0;
      sclk_d = !sclk_q;
      if (cap_o) bc_d = bc_q + 1'b1;
    end else begin
      hc_d = hc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q   <= '0;
      bc_q   <= '0;
      sclk_q <= 1'b1;
    end else begin
      hc_q   <= hc_d;
      bc_q   <= bc_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;

endmodule

// File: rtl/sadc_shift_rx.sv
module sadc_shift_rx #(
  parameter int RES_W  = 12,
  parameter int LEAD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic             last_i,
  input  logic             sdata_i,
  output logic [RES_W-1:0] data_o,
  output logic             valid_o,
  output logic             err_o
);

  localparam int FB = RES_W + LEAD_W;

  logic [FB-2:0]    sh_q;
  logic [FB-1:0]    word_w;
  logic [RES_W-1:0] data_q;
  logic             valid_q, err_q;

  assign word_w = {sh_q, sdata_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (cap_i)  sh_q   <= word_w[FB-2:0];
      if (last_i) data_q <= word_w[RES_W-1:0];
      valid_q <= last_i;
      err_q   <= last_i && (|word_w[FB-1:RES_W]);
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

endmodule

// File: rtl/sadc_host_ctrl.sv
module sadc_host_ctrl
  import sadc_pkg::*;
#(
  parameter int RES_W      = 12,
  parameter int LEAD_W     = 4,
  parameter int LOW_CYC    = 200,
  parameter int HALF_DIV   = 4,
  parameter int PERIOD_CYC = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             busy_o,
  output logic             adc_cs_n_o,
  output logic             adc_sclk_o,
  input  logic             adc_sdata_i,
  output logic [RES_W-1:0] sample_o,
  output logic             sample_valid_o,
  output logic             frame_err_o
);

  localparam int FRAME_BITS = RES_W + LEAD_W;

  logic        rst_meta_q, rst_sync_q;
  sadc_state_e st_q, st_d;
  logic        accept_w, low_done_w, period_done_w;
  logic        cap_w, last_w;
  logic        cs_n_q, busy_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign accept_w = (st_q == ST_IDLE) && start_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i)       st_d = ST_WAKE;
      ST_WAKE: if (low_done_w)    st_d = ST_XFER;
      ST_XFER: if (last_w)        st_d = ST_REST;
      ST_REST: if (period_done_w) st_d = ST_IDLE;
      default:                    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      st_q   <= ST_IDLE;
      cs_n_q <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cs_n_q <= (st_d != ST_WAKE);
      busy_q <= (st_d != ST_IDLE);
    end
  end

  sadc_frame_timer #(
    .LOW_CYC    (LOW_CYC),
    .PERIOD_CYC (PERIOD_CYC)
  ) timer_i (
    .clk           (clk),
    .rst_n         (rst_sync_q),
    .accept_i      (accept_w),
    .wake_i        (st_q == ST_WAKE),
    .low_done_o    (low_done_w),
    .period_done_o (period_done_w)
  );

  sadc_sclk_gen #(
    .HALF_DIV   (HALF_DIV),
    .FRAME_BITS (FRAME_BITS)
  ) sclk_i (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .run_i  (st_q == ST_XFER),
    .sclk_o (adc_sclk_o),
    .cap_o  (cap_w),
    .last_o (last_w)
  );

  sadc_shift_rx #(
    .RES_W  (RES_W),
    .LEAD_W (LEAD_W)
  ) rx_i (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .cap_i   (cap_w),
    .last_i  (last_w),
    .sdata_i (adc_sdata_i),
    .data_o  (sample_o),
    .valid_o (sample_valid_o),
    .err_o   (frame_err_o)
  );

  assign adc_cs_n_o = cs_n_q;
  assign busy_o     = busy_q;

endmodule

// File: rtl/sadc_host_ctrl_chk.sv
module sadc_host_ctrl_chk #(
  parameter int LOW_CYC    = 200,
  parameter int PERIOD_CYC = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic adc_cs_n_o,
  input logic adc_sclk_o,
  input logic sample_valid_o,
  input logic frame_err_o
);

  int lo_len_q;
  int since_fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_len_q     <= 0;
      since_fall_q <= PERIOD_CYC;
    end else begin
      lo_len_q <= adc_cs_n_o ? 0 : lo_len_q + 1;
      if (!adc_cs_n_o && $past(adc_cs_n_o)) since_fall_q <= 1;
      else if (since_fall_q < PERIOD_CYC)    since_fall_q <= since_fall_q + 1;
    end
  end

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (adc_cs_n_o && adc_sclk_o && !sample_valid_o));

  p_sel_falls_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n_o) |-> $past(!busy_o));

  p_low_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n_o) |-> (lo_len_q == LOW_CYC));

  p_no_clock_in_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n_o |-> adc_sclk_o);

  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid_o |=> !sample_valid_o);

  p_err_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |-> sample_valid_o);

  p_min_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n_o) |-> (since_fall_q >= PERIOD_CYC));

  p_busy_covers_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid_o |-> busy_o);

endmodule

bind sadc_host_ctrl sadc_host_ctrl_chk #(
  .LOW_CYC    (LOW_CYC),
  .PERIOD_CYC (PERIOD_CYC)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy_o         (busy_o),
  .adc_cs_n_o     (adc_cs_n_o),
  .adc_sclk_o     (adc_sclk_o),
  .sample_valid_o (sample_valid_o),
  .frame_err_o    (frame_err_o)
);

// File: tb/sadc_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module sadc_host_ctrl_tb_top;

  localparam int RES_W      = 12;
  localparam int LEAD_W     = 4;
  localparam int FB         = RES_W + LEAD_W;
  localparam int LOW_CYC    = 20;
  localparam int HALF_DIV   = 3;
  localparam int PERIOD_CYC = 300;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             busy, cs_n, sclk, valid, ferr;
  logic             sdata = 1'b0;
  logic [RES_W-1:0] sample;

  always #2.5 clk = ~clk;

  sadc_host_ctrl #(
    .RES_W(RES_W), .LEAD_W(LEAD_W), .LOW_CYC(LOW_CYC),
    .HALF_DIV(HALF_DIV), .PERIOD_CYC(PERIOD_CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy),
    .adc_cs_n_o(cs_n), .adc_sclk_o(sclk), .adc_sdata_i(sdata),
    .sample_o(sample), .sample_valid_o(valid), .frame_err_o(ferr)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // converter model: loads on select rise, drives a new bit on each clock fall
  logic [FB-1:0] adc_word = '0;
  logic [FB-1:0] adc_sh   = '0;
  always @(posedge cs_n) adc_sh = adc_word;
  always @(negedge sclk) if (cs_n === 1'b1) begin
    sdata  = adc_sh[FB-1];
    adc_sh = {adc_sh[FB-2:0], 1'b0};
  end

  // scoreboard
  typedef struct packed { logic [RES_W-1:0] d; logic e; } exp_t;
  exp_t exp_q[$];

  task automatic expect_word(input logic [FB-1:0] w);
    exp_t x;
    x.d = w[RES_W-1:0];
    x.e = |w[FB-1:RES_W];
    exp_q.push_back(x);
  endtask

  int  cyc = 0;
  always @(posedge clk) cyc++;

  bit  mon_on = 0, track_period = 0, period_armed = 0;
  int  lo_len = 0, sclk_lo = 0, rises = 0, last_fall = 0, fall_cnt = 0, wake_clk_err = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;

  always @(negedge clk) if (mon_on) begin
    if (!cs_n && !sclk) wake_clk_err++;
    if (!cs_n && prev_cs) begin
      fall_cnt++;
      if (track_period && period_armed)
        check(cyc - last_fall == PERIOD_CYC, "R7 start-to-start", cyc - last_fall, PERIOD_CYC);
      period_armed = track_period;
      last_fall = cyc;
      rises = 0;
    end
    if (!cs_n) lo_len++;
    else if (!prev_cs) begin
      check(lo_len == LOW_CYC, "R3 select low width", lo_len, LOW_CYC);
      lo_len = 0;
    end
    if (!sclk) sclk_lo++;
    else if (!prev_sclk) begin
      check(sclk_lo == HALF_DIV, "R4 clock low width", sclk_lo, HALF_DIV);
      sclk_lo = 0;
      if (cs_n) rises++;
    end
    if (ferr && !valid) check(0, "R6 flag outside strobe", 1, 0);
    if (valid) begin
      check(rises == FB, "R4 pulses per frame", rises, FB);
      check(busy, "R9 busy at strobe", busy, 1);
      if (exp_q.size() == 0) check(0, "R8 unexpected sample", sample, 0);
      else begin
        exp_t x;
        x = exp_q.pop_front();
        check(sample == x.d, "R5 sample value", sample, x.d);
        check(ferr == x.e, "R6 error flag", ferr, x.e);
      end
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic run_one(input logic [FB-1:0] w);
    adc_word = w;
    expect_word(w);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!cs_n && busy, "R2 select and busy after start", {cs_n, busy}, 2'b01);
    while (busy) @(negedge clk);
    check(exp_q.size() == 0, "R5 sample delivered", exp_q.size(), 0);
  endtask

  task automatic run_noisy(input logic [FB-1:0] w);
    int falls0;
    falls0 = fall_cnt;
    adc_word = w;
    expect_word(w);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; !valid; i++) begin
      start = (i % 3 == 0);
      @(negedge clk);
    end
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (2 * PERIOD_CYC) @(negedge clk);
    check(fall_cnt == falls0 + 1, "R8 requests while busy ignored", fall_cnt - falls0, 1);
    check(exp_q.size() == 0 && cs_n && !busy, "R8 no extra frame", exp_q.size(), 0);
  endtask

  task automatic run_held(input logic [FB-1:0] w0, input logic [FB-1:0] w1, input logic [FB-1:0] w2);
    logic [FB-1:0] ws [3];
    ws[0] = w0; ws[1] = w1; ws[2] = w2;
    track_period = 1;
    adc_word = ws[0];
    expect_word(ws[0]);
    @(negedge clk); start = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      while (!valid) @(negedge clk);
      if (k < 2) begin
        adc_word = ws[k+1];
        expect_word(ws[k+1]);
      end else start = 1'b0;
    end
    while (busy) @(negedge clk);
    track_period = 0;
    check(exp_q.size() == 0, "R7 held-start samples delivered", exp_q.size(), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check(cs_n && sclk && !busy && !valid && !ferr, "R1 state in reset",
              {cs_n, sclk, busy, valid, ferr}, 5'b11000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(cs_n && sclk && !busy && !valid && !ferr, "R1 state after reset",
              {cs_n, sclk, busy, valid, ferr}, 5'b11000);
        mon_on = 1;
        run_one(16'h0000);
        run_one(16'h0FFF);
        run_one(16'h0A5C);
        run_one(16'h0123);
        run_one(16'h8ABC);
        run_one(16'h1001);
        run_noisy(16'h0777);
        run_held(16'h0F0F, 16'h4010, 16'h0800);
        check(wake_clk_err == 0, "R4 clock quiet while select low", wake_clk_err, 0);
      end
      begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R9 watchdog expired busy actual=%0d expected=0", busy);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule